// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the host-side master for a four-wire serial EEPROM (chip select, serial clock, data in, data out) that also exposes a ready/busy status pin. A requester hands over one command at a time on a valid/ready request port. Each command carries a command code, a word address and write data. The sequencer then drives the whole transaction on the serial pins. It raises chip select, shifts out a start bit, a two-bit op code and an address field, and for data-carrying commands the data word, all most significant bit first. On a read it clocks in the returned word and drops the leading dummy bit. After a programming command it waits on the ready/busy pin, and gives up with an error once a configurable limit is reached.

The memory organization is chosen by a static input. Byte mode uses a 7-bit address and 8-bit data. Word mode uses a 6-bit address and 16-bit data. The serial clock runs at the system clock divided by `2*DIV_HALF`. The request port applies back-pressure: `req_ready` is high only while the sequencer is idle, and a requester must hold its command stable with `req_valid` high until a cycle in which both are high. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse that the requester must take when it appears.

Top module: `ee3w_host`

## Requirements
- R1: `req_ready` is 1 only while no command is in progress. A command is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until after the response pulse.
- R2: A frame starts when `ee_cs` rises. At that moment `ee_sclk` is 0 and `ee_di` carries the start bit 1. The first rising serial clock edge comes no earlier than `DIV_HALF` cycles after `ee_cs` rises. After the start bit come the op code and the address, most significant bit first.
- R3: The `req_cmd` codes map as follows. 0 is read (op 10). 1 is write (op 01, then the data word). 2 is enable (op 00, sub-code 11). 3 is disable (op 00, sub-code 00). 4 is erase-all (op 00, sub-code 10). 5 is write-all (op 00, sub-code 01, then the data word). Codes 6 and 7 behave as disable. For op 00, the sub-code occupies the two most significant address positions and the remaining address positions are sent as 0.
- R4: With `org_x16`=0, the address field is `req_addr[6:0]` and the data field is `req_wdata[7:0]`. With `org_x16`=1, the address field is `req_addr[5:0]` and the data field is `req_wdata[15:0]`. Unused request bits are not sent.
- R5: `ee_di` changes only on a falling serial clock edge, or while the serial clock is low. `ee_do` is sampled on rising edges. Each serial clock high phase and each low phase lasts at least `DIV_HALF` cycles.
- R6: After the address of a read, the sequencer gives 1 + data-width more rising edges with `ee_di` at 0. The first bit returned is a dummy and is discarded. `rsp_rdata` returns the data word, zero-extended in byte mode. For commands other than read, `rsp_rdata` is 0.
- R7: After write, erase-all and write-all, `rsp_valid` is withheld until `ee_rdy` is seen at 1. Read, enable and disable ignore `ee_rdy`.
- R8: If `ee_rdy` stays 0 for more than `BUSY_LIMIT` cycles of busy-wait, the command ends with `rsp_err`=1. Otherwise `rsp_err` is 0. `rsp_err` is 1 only together with `rsp_valid`.
- R9: `ee_sclk` is 0 whenever `ee_cs` is 0. At least `2*DIV_HALF` cycles pass between the fall of `ee_cs` and the response, and between the fall of `ee_cs` and the next rise of `ee_cs`.
- R10: Each accepted command produces exactly one `rsp_valid` pulse, one cycle long.
- R11: While `rst_n` is 0, and right after it is released, the outputs are: `ee_cs`=0, `ee_sclk`=0, `req_ready`=1 and `rsp_valid`=0. A reset in mid-frame ends the frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Sequencer idle, command can be taken |
| req_cmd | input | 3 | Command code (R3) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data for write and write-all |
| org_x16 | input | 1 | 1 selects word organization, 0 byte organization |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_valid` |
| rsp_err | output | 1 | Busy-wait timeout, valid with `rsp_valid` |
| ee_cs | output | 1 | Serial chip select, active high |
| ee_sclk | output | 1 | Serial clock, idle low |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |
| ee_rdy | input | 1 | Memory ready (1) or programming (0) |

## Verification
Some pin-level rules are checked on every cycle by the assertions. Each frame opens with the clock low and the start bit on data-in. Data-in holds still while the serial clock is high. Each clock phase lasts long enough, and chip select stays low for long enough between frames. The clock is idle whenever chip select is low. The ready, response-pulse and error-flag relations at the request port are also checked every cycle. Other behaviours can only be shown by the bench's scenarios against a model memory. These are the exact bit stream for each command in both organizations, the removal of the dummy bit on reads, and the masking of unused request bits. They also include the wait on the busy pin after programming commands only, the timeout error, and a reset in mid-frame.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

  // request command codes
  localparam logic [2:0] CMD_READ      = 3'd0;
  localparam logic [2:0] CMD_WRITE     = 3'd1;
  localparam logic [2:0] CMD_WR_EN     = 3'd2;
  localparam logic [2:0] CMD_WR_DIS    = 3'd3;
  localparam logic [2:0] CMD_ERASE_ALL = 3'd4;
  localparam logic [2:0] CMD_WRITE_ALL = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_BUSY,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] sub;
    logic       ext;
    logic       has_data;
    logic       is_read;
    logic       prog;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [2:0] code);
    cmd_dec_t d;
    d = '0;
    case (code)
      CMD_READ: begin
        d.op = 2'b10;
        d.is_read = 1'b1;
      end
      CMD_WRITE: begin
        d.op = 2'b01;
        d.has_data = 1'b1;
        d.prog = 1'b1;
      end
      CMD_WR_EN: begin
        d.ext = 1'b1;
        d.sub = 2'b11;
      end
      CMD_ERASE_ALL: begin
        d.ext = 1'b1;
        d.sub = 2'b10;
        d.prog = 1'b1;
      end
      CMD_WRITE_ALL: begin
        d.ext = 1'b1;
        d.sub = 2'b01;
        d.has_data = 1'b1;
        d.prog = 1'b1;
      end
      default: begin
        d.ext = 1'b1;
        d.sub = 2'b00;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ee3w_framer.sv
module ee3w_framer
  import ee3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  localparam int FW    = 2 + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FW + DATA_W + 2)
) (
  input  logic              org_x16,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [FW-1:0]     frame,
  output logic [CNT_W-1:0]  n_out,
  output logic [CNT_W-1:0]  n_in,
  output logic              prog
);

  localparam int AW_B = ADDR_W;
  localparam int AW_W = ADDR_W - 1;
  localparam int DW_B = DATA_W / 2;
  localparam int DW_W = DATA_W;

  cmd_dec_t          dec;
  int unsigned       aw;
  int unsigned       dw;
  int unsigned       nbits;
  logic [ADDR_W-1:0] ext_f;
  logic [ADDR_W-1:0] afield;
  logic [DATA_W-1:0] dfield;
  logic [FW-1:0]     acc;

  always_comb begin
    dec    = decode_cmd(cmd);
    aw     = org_x16 ? AW_W : AW_B;
    dw     = org_x16 ? DW_W : DW_B;
    ext_f  = {dec.sub, {(ADDR_W-2){1'b0}}};
    if (dec.ext)
      afield = org_x16 ? (ext_f >> 1) : ext_f;
    else
      afield = org_x16 ? (addr & {1'b0, {(ADDR_W-1){1'b1}}}) : addr;
    dfield = org_x16 ? wdata : DATA_W'(wdata[DW_B-1:0]);
    acc    = FW'({1'b1, dec.op});
    acc    = (acc << aw) | FW'(afield);
    nbits  = 3 + aw;
    if (dec.has_data) begin
      acc   = (acc << dw) | FW'(dfield);
      nbits = nbits + dw;
    end
    frame  = acc << (FW - nbits);
    n_out  = CNT_W'(nbits);
    n_in   = dec.is_read ? CNT_W'(1 + dw) : '0;
    prog   = dec.prog;
  end

endmodule

// File: rtl/ee3w_tick.sv
module ee3w_tick #(
  parameter int DIV_HALF = 50,
  localparam int W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || cnt == W'(DIV_HALF - 1))
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == W'(DIV_HALF - 1));

endmodule

// File: rtl/ee3w_busy_timer.sv
module ee3w_busy_timer #(
  parameter int LIMIT = 1_200_000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);

  logic [W-1:0] cnt;

  assign expired = (cnt == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!en)
      cnt <= '0;
    else if (!expired)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ee3w_host.sv
module ee3w_host
  import ee3w_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int DIV_HALF   = 50,
  parameter int BUSY_LIMIT = 1_200_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              org_x16,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ee_cs,
  output logic              ee_sclk,
  output logic              ee_di,
  input  logic              ee_do,
  input  logic              ee_rdy
);

  localparam int FW    = 2 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FW + DATA_W + 2);
  localparam int DW_B  = DATA_W / 2;

  seq_state_e        state;
  logic [FW-1:0]     shreg;
  logic [CNT_W-1:0]  edges_left;
  logic [CNT_W-1:0]  nin_r;
  logic [DATA_W-1:0] rx;
  logic              org_r;
  logic              prog_r;
  logic              cs_q;
  logic              sclk_q;
  logic              gap_half;
  logic              err_q;

  logic [FW-1:0]     fr_bits;
  logic [CNT_W-1:0]  fr_nout;
  logic [CNT_W-1:0]  fr_nin;
  logic              fr_prog;
  logic              tick;
  logic              expired;

  ee3w_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
    .org_x16 (org_x16),
    .cmd     (req_cmd),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .frame   (fr_bits),
    .n_out   (fr_nout),
    .n_in    (fr_nin),
    .prog    (fr_prog)
  );

  ee3w_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_SHIFT || state == ST_GAP),
    .tick  (tick)
  );

  ee3w_busy_timer #(.LIMIT(BUSY_LIMIT)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state == ST_BUSY),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      edges_left <= '0;
      nin_r      <= '0;
      rx         <= '0;
      org_r      <= 1'b0;
      prog_r     <= 1'b0;
      cs_q       <= 1'b0;
      sclk_q     <= 1'b0;
      gap_half   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            shreg      <= fr_bits;
            edges_left <= fr_nout + fr_nin;
            nin_r      <= fr_nin;
            prog_r     <= fr_prog;
            org_r      <= org_x16;
            rx         <= '0;
            err_q      <= 1'b0;
            gap_half   <= 1'b0;
            cs_q       <= 1'b1;
            sclk_q     <= 1'b0;
            state      <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              if (edges_left <= nin_r)
                rx <= {rx[DATA_W-2:0], ee_do};
            end else begin
              sclk_q     <= 1'b0;
              shreg      <= {shreg[FW-2:0], 1'b0};
              edges_left <= edges_left - 1'b1;
              if (edges_left == CNT_W'(1)) begin
                cs_q  <= 1'b0;
                state <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            gap_half <= 1'b1;
            if (gap_half)
              state <= prog_r ? ST_BUSY : ST_DONE;
          end
        end
        ST_BUSY: begin
          if (ee_rdy) begin
            state <= ST_DONE;
          end else if (expired) begin
            err_q <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_rdata = !rsp_valid ? '0 :
                     (org_r ? rx : DATA_W'(rx[DW_B-1:0]));
  assign ee_cs     = cs_q;
  assign ee_sclk   = sclk_q;
  assign ee_di     = cs_q && shreg[FW-1];

endmodule

// File: rtl/ee3w_host_chk.sv
module ee3w_host_chk #(
  parameter int DIV_HALF = 50
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic ee_cs,
  input logic ee_sclk,
  input logic ee_di
);

  logic [15:0] run_len;
  logic [15:0] low_len;
  logic        sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '1;
      low_len <= '1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_d  <= ee_sclk;
      if (ee_sclk != sclk_d) run_len <= '0;
      else if (run_len != '1) run_len <= run_len + 1'b1;
      if (ee_cs) low_len <= '0;
      else if (low_len != '1) low_len <= low_len + 1'b1;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ee_cs && !ee_sclk));

  p_cs_rise_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (ee_di && !ee_sclk));

  p_di_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sclk |-> $stable(ee_di));

  p_half_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sclk != sclk_d) |-> (run_len >= 16'(DIV_HALF - 1)));

  p_clk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sclk);

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (low_len >= 16'(2 * DIV_HALF)));

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind ee3w_host ee3w_host_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .ee_cs     (ee_cs),
  .ee_sclk   (ee_sclk),
  .ee_di     (ee_di)
);

// File: tb/ee3w_host_test.sv
module ee3w_host_test;

  localparam int DH  = 2;
  localparam int LIM = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = '0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        org_x16 = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        ee_cs;
  logic        ee_sclk;
  logic        ee_di;
  logic        ee_do = 1'b0;
  logic        ee_rdy = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ee3w_host #(.ADDR_W(7), .DATA_W(16), .DIV_HALF(DH), .BUSY_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .org_x16(org_x16),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_di(ee_di),
    .ee_do(ee_do), .ee_rdy(ee_rdy)
  );

  // memory-side model
  logic        sl_read = 0, sl_prog = 0;
  int          sl_aw = 7, sl_dw = 8, sl_busy = 0;
  logic [15:0] sl_pat = '0;
  logic [31:0] sl_cap = '0;
  int          sl_cnt = 0, bcnt = 0, run = 0, min_half = 1000, gap = 0;
  logic        sclk_q = 0, cs_q = 0, di_q = 0, di_bad = 0;

  always @(posedge clk) begin : slave
    int k;
    sclk_q <= ee_sclk;
    cs_q   <= ee_cs;
    di_q   <= ee_di;
    if (ee_sclk && ee_di != di_q) di_bad <= 1'b1;
    if (ee_cs && !cs_q) begin
      sl_cnt <= 0; sl_cap <= '0; run <= 1; min_half <= 1000; di_bad <= 1'b0;
    end else begin
      if (ee_sclk != sclk_q) begin
        if (run < min_half) min_half <= run;
        run <= 1;
      end else run <= run + 1;
      if (ee_sclk && !sclk_q && ee_cs) begin
        k = sl_cnt + 1;
        sl_cnt <= k;
        sl_cap <= {sl_cap[30:0], ee_di};
        if (sl_read && k == 3 + sl_aw) ee_do <= 1'b0;
        else if (sl_read && k > 3 + sl_aw && k <= 3 + sl_aw + sl_dw)
          ee_do <= sl_pat[sl_dw - 1 - (k - 4 - sl_aw)];
      end
    end
    if (!ee_cs && cs_q) begin
      gap <= 0;
      if (sl_prog) begin ee_rdy <= 1'b0; bcnt <= sl_busy; end
    end else begin
      gap <= gap + 1;
      if (!ee_rdy) begin
        if (bcnt == 0) ee_rdy <= 1'b1; else bcnt <= bcnt - 1;
      end
    end
  end

  typedef struct packed {
    logic        org;
    logic [2:0]  cmd;
    logic [6:0]  addr;
    logic [15:0] wd;
    logic [15:0] pat;
    logic [11:0] busy;
    logic [5:0]  len;
    logic [15:0] rd;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 3'd0, 7'h55, 16'h0000, 16'h00A5, 12'd0,  6'd19, 16'h00A5},
    '{1'b1, 3'd0, 7'h2A, 16'h0000, 16'hBEEF, 12'd0,  6'd26, 16'hBEEF},
    '{1'b0, 3'd1, 7'h7F, 16'hFF3C, 16'h0000, 12'd20, 6'd18, 16'h0000},
    '{1'b1, 3'd1, 7'h01, 16'h8001, 16'h0000, 12'd50, 6'd25, 16'h0000},
    '{1'b0, 3'd2, 7'h13, 16'h0000, 16'h0000, 12'd0,  6'd10, 16'h0000},
    '{1'b1, 3'd3, 7'h7F, 16'h0000, 16'h0000, 12'd0,  6'd9,  16'h0000},
    '{1'b0, 3'd4, 7'h00, 16'h0000, 16'h0000, 12'd30, 6'd10, 16'h0000},
    '{1'b1, 3'd5, 7'h3C, 16'h1234, 16'h0000, 12'd10, 6'd25, 16'h0000},
    '{1'b1, 3'd0, 7'h7F, 16'h0000, 16'h0001, 12'd0,  6'd26, 16'h0001},
    '{1'b0, 3'd7, 7'h7F, 16'hFFFF, 16'h0000, 12'd0,  6'd10, 16'h0000}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected serial stream, right-aligned (R2 R3 R4 R6)
  function automatic logic [31:0] exp_bits(input logic org, input logic [2:0] cmd,
                                           input logic [6:0] addr, input logic [15:0] wd);
    int aw = org ? 6 : 7;
    int dw = org ? 16 : 8;
    logic [1:0] op = 2'b00;
    logic [1:0] sub = 2'b00;
    logic       data = 0, rd = 0;
    logic [31:0] b;
    logic [6:0]  a;
    case (cmd)
      3'd0: begin op = 2'b10; rd = 1; end
      3'd1: begin op = 2'b01; data = 1; end
      3'd2: sub = 2'b11;
      3'd4: sub = 2'b10;
      3'd5: begin sub = 2'b01; data = 1; end
      default: sub = 2'b00;
    endcase
    if (cmd == 3'd0 || cmd == 3'd1) a = addr & 7'((1 << aw) - 1);
    else a = 7'(sub << (aw - 2));
    b = 32'd1;
    b = (b << 2) | 32'(op);
    b = (b << aw) | 32'(a);
    if (data) b = (b << dw) | (32'(wd) & ((32'd1 << dw) - 1));
    if (rd) b = b << (1 + dw);
    return b;
  endfunction

  logic [15:0] got_rd;
  logic        got_err, got_rdy, saw_rsp;
  int          lat;

  task automatic run_cmd(input logic org, input logic [2:0] cmd, input logic [6:0] addr,
                         input logic [15:0] wd, input logic [15:0] pat, input int busy);
    @(negedge clk);
    sl_read = (cmd == 3'd0);
    sl_prog = (cmd == 3'd1 || cmd == 3'd4 || cmd == 3'd5);
    sl_aw = org ? 6 : 7; sl_dw = org ? 16 : 8;
    sl_pat = pat; sl_busy = busy;
    org_x16 = org; req_cmd = cmd; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
    saw_rsp = 0; lat = 0;
    for (int c = 0; c < 5000 && !saw_rsp; c++) begin
      if (rsp_valid) begin
        saw_rsp = 1; got_rd = rsp_rdata; got_err = rsp_err; got_rdy = ee_rdy;
        check(gap + 1 >= 2 * DH, "R9 cs low before done", gap + 1, 2 * DH);
      end else begin
        lat++;
        @(negedge clk);
      end
    end
    check(saw_rsp, "R10 response seen", saw_rsp, 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 single pulse", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] eb, msk;
    repeat (3) @(negedge clk);
    check(ee_cs == 0 && ee_sclk == 0, "R11 pins in reset", {ee_cs, ee_sclk}, 0);
    check(req_ready == 1 && rsp_valid == 0, "R11 handshake in reset", {req_ready, rsp_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(ee_cs == 0 && req_ready == 1, "R11 after release", {ee_cs, req_ready}, 1);

    for (int i = 0; i < 10; i++) begin
      run_cmd(VEC[i].org, VEC[i].cmd, VEC[i].addr, VEC[i].wd, VEC[i].pat, int'(VEC[i].busy));
      eb  = exp_bits(VEC[i].org, VEC[i].cmd, VEC[i].addr, VEC[i].wd);
      msk = (32'd1 << VEC[i].len) - 1;
      check(sl_cnt == int'(VEC[i].len), "R4 frame length", sl_cnt, VEC[i].len);
      check((sl_cap & msk) == eb, "R2 R3 frame bits", sl_cap & msk, eb);
      check(got_rd == VEC[i].rd, "R6 returned word", got_rd, VEC[i].rd);
      check(got_err == 1'b0, "R8 no error", got_err, 0);
      check(got_rdy == 1'b1, "R7 done only when ready", got_rdy, 1);
      check(!di_bad, "R5 data-in stable while clock high", di_bad, 0);
      check(min_half >= DH, "R5 clock phase length", min_half, DH);
      if (VEC[i].busy != 0)
        check(lat > int'(VEC[i].busy), "R7 waits for busy", lat, VEC[i].busy);
    end

    // R8: busy beyond the limit
    run_cmd(1'b0, 3'd1, 7'h11, 16'h00AA, 16'h0000, 1000);
    check(got_err == 1'b1, "R8 timeout error", got_err, 1);
    check(got_rdy == 1'b0, "R8 still busy at timeout", got_rdy, 0);
    // R7: enable does not wait on the busy pin
    run_cmd(1'b0, 3'd2, 7'h00, 16'h0000, 16'h0000, 0);
    check(got_err == 1'b0 && ee_rdy == 1'b0, "R7 enable ignores busy", {got_err, ee_rdy}, 0);
    check(lat < 100, "R7 enable latency", lat, 100);
    while (!ee_rdy) @(negedge clk);

    // R11: reset during a frame
    @(negedge clk);
    sl_read = 1; sl_prog = 0; org_x16 = 1'b1; req_cmd = 3'd0; req_addr = 7'h05;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ee_cs == 0 && ee_sclk == 0, "R11 mid-frame reset pins", {ee_cs, ee_sclk}, 0);
    check(req_ready == 1'b1, "R11 mid-frame reset ready", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    // command after reset still works (R6)
    run_cmd(1'b1, 3'd0, 7'h21, 16'h0000, 16'h5A0F, 0);
    check(got_rd == 16'h5A0F, "R6 read after reset", got_rd, 16'h5A0F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule